// File: doc/BRIEF.md
# Supply Under-voltage Fault Mode Controller

This block decides how a device reacts when a regulated supply rail sags. A comparator elsewhere raises a single under-voltage flag. The controller waits until that flag has been asserted for a programmable number of clock cycles before it acts. It then pulls an active-low reset output low and moves into one of two fault modes. Fail-safe mode waits for a wake event. Restart mode waits for the rail to recover.

The choice between the two modes depends on how the device is controlled. When it is strapped for pin control, fail-safe is always used. When it is under serial-register control, a one-bit fail-safe-disable setting picks restart mode instead. Entering either fault mode starts an inactivity timer. Under register control, entry also bumps a saturating entry counter and raises a sticky interrupt flag. In fail-safe mode, a wake event with the rail recovered returns the device to normal operation. A wake event while the rail is still low, or expiry of the timer, drops the device into sleep.

Top module: `uvf_mode_ctrl`

## Requirements
- R1: After reset, `mode` reads 0 (normal), `rst_out_n` is 1, `mode_cnt` is 0, `irq_flags` is 0 and the fail-safe-disable setting is 0.
- R2: The block acts on an under-voltage only after `uv_flag` has been sampled high on FILT_CYC consecutive clock edges, and `mode` changes on the edge after that. A single sampled low restarts the count.
- R3: `rst_out_n` is 0 whenever `mode` is 1 (restart), 2 (fail-safe) or 3 (sleep), and it is 1 in mode 0 (normal).
- R4: With `pin_ctrl` = 0, a qualified under-voltage enters restart (mode 1) if the setting last written through `cfg_we`/`cfg_fs_dis` is 1, and fail-safe (mode 2) if it is 0.
- R5: With `pin_ctrl` = 1, a qualified under-voltage always enters fail-safe (mode 2), whatever the setting. Such an entry leaves `mode_cnt` and `irq_flags` unchanged.
- R6: With `pin_ctrl` = 0, every entry into mode 1 or 2 adds one to `mode_cnt`. Entry into restart sets `irq_flags[0]`, and entry into fail-safe sets `irq_flags[1]`.
- R7: If restart or fail-safe is not left by other means, the block moves to sleep (mode 3) on the SWE_CYC-th edge after entry.
- R8: In fail-safe, a sampled `wake` with `uv_flag` low moves to normal on the next edge. A sampled `wake` with `uv_flag` high moves to sleep. A wake takes precedence over the timer.
- R9: In restart, a sampled low `uv_flag` moves to normal on the next edge, and no wake is needed.
- R10: In sleep, a `wake` with `uv_flag` low moves to normal on the next edge. A `wake` with `uv_flag` high leaves the block in sleep.
- R11: `mode_cnt` saturates at 2^CNT_W-1 and does not wrap.
- R12: A 1 on `irq_clr[i]` clears `irq_flags[i]` on the next edge and leaves the other flag alone. A set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag | input | 1 | Comparator under-voltage flag, high = rail at or below threshold |
| wake | input | 1 | Wake event, sampled each edge |
| pin_ctrl | input | 1 | 1 = pin control strap, 0 = register control |
| cfg_we | input | 1 | Write strobe for the fail-safe-disable setting |
| cfg_fs_dis | input | 1 | Value written: 1 disables fail-safe under register control |
| irq_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| rst_out_n | output | 1 | Active-low reset to the host |
| mode | output | 2 | 0 normal, 1 restart, 2 fail-safe, 3 sleep |
| mode_cnt | output | CNT_W | Saturating count of fault-mode entries under register control |
| irq_flags | output | 2 | Bit 0 restart entry, bit 1 fail-safe entry (sticky) |

## Verification
An under-voltage raised before an edge first shows in `mode` after FILT_CYC+1 edges. Entry-counter and flag updates land on that same edge. The bench drives inputs on falling edges and samples on the falling edge after the exact number of rising edges for each result. It checks one edge early to confirm nothing moved too soon. Exits on wake or recovery are due one edge later, timer expiry is due SWE_CYC edges after entry, and the timer is probed at SWE_CYC-1 edges as well.

// File: rtl/uvf_pkg.sv
// Package: shared mode encoding and flag indices for the under-voltage
// fault mode controller. Assumes a 2-bit mode bus is visible to software.
package uvf_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_RESTART  = 2'd1,
        MODE_FAILSAFE = 2'd2,
        MODE_SLEEP    = 2'd3
    } uvf_mode_e;

    localparam int IRQ_W        = 2;
    localparam int IRQ_RESTART  = 0;
    localparam int IRQ_FAILSAFE = 1;
endpackage

// File: rtl/uvf_filter.sv
// Qualifies the raw under-voltage flag: counts consecutive sampled-high
// cycles and reports qualified once FILT_CYC is reached. Assumes uv_flag
// is already synchronous to clk.
module uvf_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    output logic uv_qual
);
    localparam int FCW = (FILT_CYC > 0) ? $clog2(FILT_CYC + 1) : 1;
    localparam logic [FCW-1:0] LIMIT = FCW'(FILT_CYC);

    logic [FCW-1:0] cnt_q;

    // Count consecutive high samples, saturate at the limit, restart on low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!uv_flag) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualified once the full filter time has elapsed.
    assign uv_qual = (cnt_q == LIMIT);

    // R2
    filt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_flag |=> !uv_qual);
endmodule

// File: rtl/uvf_swe_timer.sv
// Sleep/wake error timer: restarted by start, counts while run is high,
// flags expiry when SWE_CYC-1 cycles have elapsed since start. Assumes
// SWE_CYC >= 2.
module uvf_swe_timer #(
    parameter int SWE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int TW = (SWE_CYC > 1) ? $clog2(SWE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(SWE_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Restart on start, otherwise advance while running until the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry is only meaningful while the timer is running.
    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/uvf_sat_cnt.sv
// Saturating up-counter for fault-mode entries. Assumes inc is a
// single-cycle pulse per event.
module uvf_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_q;

    // Add one per event, hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX) |=> (cnt_q == MAX));
endmodule

// File: rtl/uvf_mode_ctrl.sv
// Top: under-voltage fault mode controller. Filters the comparator flag,
// chooses restart or fail-safe from the control strap and the disable
// setting, runs the inactivity timer, counts entries and raises sticky
// flags. Assumes all inputs are synchronous to clk.
module uvf_mode_ctrl
    import uvf_pkg::*;
#(
    parameter int FILT_CYC = 4,
    parameter int SWE_CYC  = 16,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uv_flag,
    input  logic             wake,
    input  logic             pin_ctrl,
    input  logic             cfg_we,
    input  logic             cfg_fs_dis,
    input  logic [IRQ_W-1:0] irq_clr,
    output logic             rst_out_n,
    output logic [1:0]       mode,
    output logic [CNT_W-1:0] mode_cnt,
    output logic [IRQ_W-1:0] irq_flags
);
    uvf_mode_e        mode_q, mode_d;
    logic             fs_dis_q;
    logic             fs_en;
    logic             uv_qual;
    logic             entry;
    logic             in_fault;
    logic             tmr_exp;
    logic [IRQ_W-1:0] irq_q, irq_set;

    // Fail-safe-disable setting, written through the simple port.
    always_ff @(posedge clk) begin
        if (!rst_n)      fs_dis_q <= 1'b0;
        else if (cfg_we) fs_dis_q <= cfg_fs_dis;
    end

    // Pin control forces fail-safe; register control honours the setting.
    assign fs_en = pin_ctrl || !fs_dis_q;

    uvf_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_flag (uv_flag),
        .uv_qual (uv_qual)
    );

    assign entry    = (mode_q == MODE_NORMAL) && uv_qual;
    assign in_fault = (mode_q == MODE_RESTART) || (mode_q == MODE_FAILSAFE);

    uvf_swe_timer #(.SWE_CYC(SWE_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (entry),
        .run     (in_fault),
        .expired (tmr_exp)
    );

    // Next-mode decision: wake and recovery win over the timer.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: begin
                if (uv_qual) mode_d = fs_en ? MODE_FAILSAFE : MODE_RESTART;
            end
            MODE_RESTART: begin
                if (!uv_flag)     mode_d = MODE_NORMAL;
                else if (tmr_exp) mode_d = MODE_SLEEP;
            end
            MODE_FAILSAFE: begin
                if (wake)         mode_d = uv_flag ? MODE_SLEEP : MODE_NORMAL;
                else if (tmr_exp) mode_d = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (wake && !uv_flag) mode_d = MODE_NORMAL;
            end
            default: mode_d = MODE_NORMAL;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    uvf_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (entry && !pin_ctrl),
        .count (mode_cnt)
    );

    // Flag set requests: one per fault mode, register control only.
    always_comb begin
        irq_set               = '0;
        irq_set[IRQ_RESTART]  = entry && !pin_ctrl && !fs_en;
        irq_set[IRQ_FAILSAFE] = entry && !pin_ctrl && fs_en;
    end

    // Sticky flags, write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            for (int i = 0; i < IRQ_W; i++) begin
                if (irq_set[i])      irq_q[i] <= 1'b1;
                else if (irq_clr[i]) irq_q[i] <= 1'b0;
            end
        end
    end

    assign rst_out_n = (mode_q == MODE_NORMAL);
    assign mode      = mode_q;
    assign irq_flags = irq_q;

    // R2
    no_early_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL && !uv_qual) |=> (mode_q == MODE_NORMAL));
    // R4
    spi_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && !pin_ctrl && fs_dis_q) |=> (mode_q == MODE_RESTART));
    // R5
    pin_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && pin_ctrl) |=> (mode_q == MODE_FAILSAFE && $stable(mode_cnt)));
    // R7
    fs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FAILSAFE && tmr_exp && !wake) |=> (mode_q == MODE_SLEEP));
    // R8
    fs_wake_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FAILSAFE && wake && uv_flag) |=> (mode_q == MODE_SLEEP));
    // R3
    rst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_fault) |-> !rst_out_n);
endmodule

// File: tb/sim_uvf_mode_ctrl.sv
module sim_uvf_mode_ctrl;
    localparam int CLK_PER  = 10;
    localparam int FILT_CYC = 4;
    localparam int SWE_CYC  = 16;
    localparam int CNT_W    = 4;
    // Vector fields: {pin_ctrl, fs_dis, expected mode[1:0]}
    localparam logic [3:0] VEC [4] = '{4'b0010, 4'b0101, 4'b1110, 4'b1010};

    logic clk = 1'b0, rst_n = 1'b0, uv_flag = 1'b0, wake = 1'b0;
    logic pin_ctrl = 1'b0, cfg_we = 1'b0, cfg_fs_dis = 1'b0;
    logic [1:0] irq_clr = '0;
    logic rst_out_n;
    logic [1:0] mode;
    logic [CNT_W-1:0] mode_cnt;
    logic [1:0] irq_flags;

    int n_chk = 0, n_fail = 0;
    int exp_cnt = 0;
    logic [1:0] exp_irq = '0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    uvf_mode_ctrl #(.FILT_CYC(FILT_CYC), .SWE_CYC(SWE_CYC), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .wake(wake),
        .pin_ctrl(pin_ctrl), .cfg_we(cfg_we), .cfg_fs_dis(cfg_fs_dis),
        .irq_clr(irq_clr), .rst_out_n(rst_out_n), .mode(mode),
        .mode_cnt(mode_cnt), .irq_flags(irq_flags));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic v);
        cfg_we = 1'b1; cfg_fs_dis = v;
        tick();
        cfg_we = 1'b0;
    endtask

    // Raise the flag and wait until the mode is due (model update for R6).
    task automatic enter_fault(input logic fs_dis);
        uv_flag = 1'b1;
        repeat (FILT_CYC + 1) tick();
        if (!pin_ctrl) begin
            if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
            exp_irq |= fs_dis ? 2'b01 : 2'b10;
        end
    endtask

    task automatic leave_ok();
        uv_flag = 1'b0; wake = 1'b1;
        tick();
        wake = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 rst_out_n", rst_out_n, 1);
        check("R1 mode_cnt", mode_cnt, 0);
        check("R1 irq", irq_flags, 0);
        rst_n = 1'b1;
        tick();

        // Table walk: control method x disable setting (R4, R5, R6, R3, R8, R9)
        for (int i = 0; i < 4; i++) begin
            pin_ctrl = VEC[i][3];
            write_cfg(VEC[i][2]);
            enter_fault(VEC[i][2]);
            check("R4/R5 mode", mode, int'(VEC[i][1:0]));
            check("R3 rst low", rst_out_n, 0);
            check("R6/R5 mode_cnt", mode_cnt, exp_cnt);
            check("R6/R5 irq", irq_flags, exp_irq);
            uv_flag = 1'b0;
            if (VEC[i][1:0] == 2'd2) wake = 1'b1;
            tick();
            wake = 1'b0;
            check("R8/R9 exit", mode, 0);
            check("R3 rst high", rst_out_n, 1);
        end

        // R2 filter restart on a glitch
        pin_ctrl = 1'b0;
        write_cfg(1'b0);
        uv_flag = 1'b1;
        repeat (FILT_CYC - 1) tick();
        uv_flag = 1'b0;
        tick();
        uv_flag = 1'b1;
        repeat (FILT_CYC) tick();
        check("R2 not yet", mode, 0);
        tick();
        check("R2 entered", mode, 2);
        if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
        exp_irq |= 2'b10;

        // R8 wake while rail low -> sleep; R10 sleep exits
        wake = 1'b1;
        tick();
        wake = 1'b0;
        check("R8 wake uv high", mode, 3);
        check("R3 sleep rst", rst_out_n, 0);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        check("R10 stay sleep", mode, 3);
        leave_ok();
        check("R10 sleep exit", mode, 0);

        // R7 timer expiry from fail-safe
        enter_fault(1'b0);
        check("R7 fs entered", mode, 2);
        repeat (SWE_CYC - 1) tick();
        check("R7 fs before expiry", mode, 2);
        tick();
        check("R7 fs expired", mode, 3);
        leave_ok();

        // R7 timer expiry from restart
        write_cfg(1'b1);
        enter_fault(1'b1);
        check("R7 restart entered", mode, 1);
        repeat (SWE_CYC - 1) tick();
        check("R7 restart before expiry", mode, 1);
        tick();
        check("R7 restart expired", mode, 3);
        leave_ok();
        check("R7 back to normal", mode, 0);

        // R12 write-one-to-clear, per bit
        check("R12 both set", irq_flags, exp_irq);
        irq_clr = 2'b10;
        tick();
        irq_clr = 2'b00;
        check("R12 clear bit1", irq_flags, 1);
        irq_clr = 2'b01;
        tick();
        irq_clr = 2'b00;
        check("R12 clear bit0", irq_flags, 0);

        // R11 saturation of the entry counter
        write_cfg(1'b0);
        for (int k = 0; k < 20; k++) begin
            enter_fault(1'b0);
            leave_ok();
        end
        check("R11 saturated", mode_cnt, (1 << CNT_W) - 1);
        check("R11 model", exp_cnt, (1 << CNT_W) - 1);

        report();
    end
endmodule